// File: doc/BRIEF.md
# Four-way tree pseudo-LRU victim selector

This block holds the replacement state of a single set in a four-way set-associative cache and names the way to evict next. The state is a three-bit binary decision tree. Its root node picks a pair of ways: the low pair (ways 0 and 1) or the high pair (ways 2 and 3). Each of the two leaf nodes then picks one way within its pair. Each hit or fill into the set is reported with a one-cycle reference strobe and the way number. On the following clock edge, the two tree nodes on that way's path are pointed away from it.

A valid bit per way comes in alongside. If any way in the set is empty, that way is the victim and the tree is not used. If several are empty, the lowest-numbered one wins. The victim output is purely combinational from the current tree and the valid vector, so a cache controller can read it in the same cycle as its lookup. Tag storage, the array holding the state of every set, and data paths live outside this block.

Top module: `plru4_victim_sel`

## Requirements
- R1: While reset is asserted, and after reset with no reference made, all three tree nodes are 0. With every way valid, the victim is therefore way 0.
- R2: When `way_valid` is not all ones, `victim_way` is the lowest index whose valid bit is 0, whatever the tree state. `way_valid` bit k belongs to way k.
- R3: When all ways are valid, the walk starts at the root node. Root 0 leads to the low-pair node, where 0 gives way 0 and 1 gives way 1. Root 1 leads to the high-pair node, where 0 gives way 2 and 1 gives way 3.
- R4: A reference to way 0 sets the root and the low-pair node to 1. The high-pair node keeps its value.
- R5: A reference to way 1 sets the root to 1 and the low-pair node to 0. The high-pair node keeps its value.
- R6: A reference to way 2 sets the root to 0 and the high-pair node to 1. The low-pair node keeps its value.
- R7: A reference to way 3 sets the root to 0 and the high-pair node to 0. The low-pair node keeps its value.
- R8: In a cycle with `ref_vld` low, the tree keeps its value whatever `ref_way` carries.
- R9: `victim_way` follows a change on `way_valid` within the same cycle. A reference changes `victim_way` only after the rising clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_vld | input | 1 | A hit or fill touched this set in this cycle |
| ref_way | input | 2 | Way touched by the reference |
| way_valid | input | 4 | Per-way valid bits, bit k for way k |
| victim_way | output | 2 | Way to replace next |

## Verification
The bench steps through the four references in a chain in which each one visibly moves the victim. A design that swapped the bit sense of a node, or that touched the node of the other pair, would name the wrong way after one of these steps. It also presents partly valid sets while the tree points elsewhere, and with several holes at once. Letting the tree win, or choosing the highest empty way, shows up at once.

The bench holds `ref_vld` low while `ref_way` wanders, to catch an update that ignores the strobe. Finally, a long random run compares every cycle against a behavioural model. This exposes any victim that changes one cycle early or late.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

  // Depth of a node in a heap-ordered tree: node 0 at depth 0, 1..2 at 1, ...
  function automatic int node_depth(input int node);
    return $clog2(node + 2) - 1;
  endfunction

endpackage

// File: rtl/plru4_rst_sync.sv
module plru4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/plru4_tree_state.sv
module plru4_tree_state
  import plru4_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int IDX_W  = $clog2(WAYS),
  localparam int NODES  = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_vld,
  input  logic [IDX_W-1:0] ref_way,
  output logic [NODES-1:0] tree_q
);
  logic [NODES-1:0] tree_d;
  logic             tree_en;

  assign tree_en = ref_vld;

  // Each node on the referenced way's path points away from that way.
  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int DEPTH = node_depth(n);
    localparam int POS   = n - ((1 << DEPTH) - 1);
    localparam int SEL   = IDX_W - 1 - DEPTH;
    localparam logic [IDX_W-1:0] POS_V = IDX_W'(POS);
    logic on_path;
    assign on_path  = (ref_way >> (IDX_W - DEPTH)) == POS_V;
    assign tree_d[n] = on_path ? ~ref_way[SEL] : tree_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tree_q <= '0;
    else if (tree_en) tree_q <= tree_d;
  end
endmodule

// File: rtl/plru4_tree_walk.sv
module plru4_tree_walk #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree,
  output logic [IDX_W-1:0] walk_way
);
  logic [WAYS-1:0] reach;

  // A way is reached when every node on its path points toward it.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [IDX_W-1:0] step_ok;
    for (genvar l = 0; l < IDX_W; l++) begin : g_lvl
      localparam int  NODE = ((1 << l) - 1) + (w >> (IDX_W - l));
      localparam bit  DIR  = bit'((w >> (IDX_W - 1 - l)) & 1);
      assign step_ok[l] = (tree[NODE] == DIR);
    end
    assign reach[w] = &step_ok;
  end

  always_comb begin
    walk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (reach[w]) walk_way = walk_way | IDX_W'(w);
    end
  end
endmodule

// File: rtl/plru4_hole_pick.sv
module plru4_hole_pick #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  output logic             hole_any,
  output logic [IDX_W-1:0] hole_way
);
  assign hole_any = ~&way_valid;

  always_comb begin
    hole_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) hole_way = IDX_W'(w);
    end
  end
endmodule

// File: rtl/plru4_victim_sel.sv
module plru4_victim_sel #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_vld,
  input  logic [IDX_W-1:0] ref_way,
  input  logic [WAYS-1:0]  way_valid,
  output logic [IDX_W-1:0] victim_way
);
  logic             rst_sync_n;
  logic [NODES-1:0] tree_q;
  logic [IDX_W-1:0] walk_way;
  logic [IDX_W-1:0] hole_way;
  logic             hole_any;

  plru4_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  plru4_tree_state #(.WAYS(WAYS)) u_state (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ref_vld(ref_vld),
    .ref_way(ref_way),
    .tree_q (tree_q)
  );

  plru4_tree_walk #(.WAYS(WAYS)) u_walk (
    .tree    (tree_q),
    .walk_way(walk_way)
  );

  plru4_hole_pick #(.WAYS(WAYS)) u_hole (
    .way_valid(way_valid),
    .hole_any (hole_any),
    .hole_way (hole_way)
  );

  assign victim_way = hole_any ? hole_way : walk_way;
endmodule

// File: rtl/plru4_victim_sel_chk.sv
module plru4_victim_sel_chk #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             ref_vld,
  input logic [IDX_W-1:0] ref_way,
  input logic [WAYS-1:0]  way_valid,
  input logic [IDX_W-1:0] victim_way,
  input logic [NODES-1:0] tree_q
);
  p_hole_is_empty_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (way_valid != 4'hF) |-> !way_valid[victim_way]);

  p_hole_is_lowest_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (way_valid != 4'hF) |-> (((~way_valid) & ((4'd1 << victim_way) - 4'd1)) == 4'd0));

  p_root_pair_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (way_valid == 4'hF) |-> (victim_way[1] == tree_q[0]));

  p_ref_way0_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_vld && ref_way == 2'd0) |=> (tree_q[0] && tree_q[1] && tree_q[2] == $past(tree_q[2])));

  p_ref_way1_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_vld && ref_way == 2'd1) |=> (tree_q[0] && !tree_q[1] && tree_q[2] == $past(tree_q[2])));

  p_ref_way2_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_vld && ref_way == 2'd2) |=> (!tree_q[0] && tree_q[2] && tree_q[1] == $past(tree_q[1])));

  p_ref_way3_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_vld && ref_way == 2'd3) |=> (!tree_q[0] && !tree_q[2] && tree_q[1] == $past(tree_q[1])));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ref_vld |=> $stable(tree_q));
endmodule

bind plru4_victim_sel plru4_victim_sel_chk #(.WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .ref_vld   (ref_vld),
  .ref_way   (ref_way),
  .way_valid (way_valid),
  .victim_way(victim_way),
  .tree_q    (tree_q)
);

// File: tb/plru4_victim_sel_bench.sv
`timescale 1ns/1ps
module plru4_victim_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_vld;
  logic [1:0] ref_way;
  logic [3:0] way_valid;
  logic [1:0] victim_way;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural model of the three tree nodes
  int m_root, m_lo, m_hi;

  always #2.5 clk = ~clk;

  plru4_victim_sel u_plru4_victim_sel (
    .clk(clk), .rst_n(rst_n), .ref_vld(ref_vld), .ref_way(ref_way),
    .way_valid(way_valid), .victim_way(victim_way)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_root = 0; m_lo = 0; m_hi = 0;
    end else if (ref_vld) begin
      case (ref_way)
        2'd0: begin m_root = 1; m_lo = 1; end
        2'd1: begin m_root = 1; m_lo = 0; end
        2'd2: begin m_root = 0; m_hi = 1; end
        default: begin m_root = 0; m_hi = 0; end
      endcase
    end
  end

  function automatic int model_victim(input logic [3:0] vld);
    for (int k = 0; k < 4; k++) if (!vld[k]) return k;
    if (m_root == 0) return (m_lo != 0) ? 1 : 0;
    return (m_hi != 0) ? 3 : 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: victim_way=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ref_and_check(input logic [1:0] w, input int exp, input string tag);
    @(negedge clk);
    way_valid = 4'hF; ref_vld = 1'b1; ref_way = w;
    #1 check({tag, "/R9 before edge"}, int'(victim_way), model_victim(way_valid));
    @(negedge clk);
    ref_vld = 1'b0;
    #1 check(tag, int'(victim_way), exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_vld = 1'b0; ref_way = 2'd0; way_valid = 4'hF;
    #1 check("R1 in reset", int'(victim_way), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1 after reset", int'(victim_way), 0);

    // R2 / R9: holes, seen in the same cycle
    way_valid = 4'b1110; #1 check("R2 hole 0", int'(victim_way), 0);
    way_valid = 4'b1011; #1 check("R2 R9 hole 2", int'(victim_way), 2);
    way_valid = 4'b0000; #1 check("R2 all empty", int'(victim_way), 0);
    way_valid = 4'b0111; #1 check("R2 hole 3", int'(victim_way), 3);
    way_valid = 4'b0101; #1 check("R2 holes 1,3", int'(victim_way), 1);

    // R4..R7 chain
    ref_and_check(2'd0, 2, "R4 ref 0");
    @(negedge clk); way_valid = 4'b1101;
    #1 check("R2 tree ignored", int'(victim_way), 1);
    way_valid = 4'hF;
    #1 check("R3 root high, hi node 0", int'(victim_way), 2);
    ref_and_check(2'd2, 1, "R6 ref 2");
    ref_and_check(2'd1, 3, "R5 ref 1");
    ref_and_check(2'd3, 0, "R7 ref 3");
    ref_and_check(2'd1, 2, "R5 ref 1 again");

    // R8: no strobe, ref_way wanders
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ref_vld = 1'b0; ref_way = 2'(i); way_valid = 4'hF;
      #1 check("R8 idle hold", int'(victim_way), 2);
    end

    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ref_vld   = ($urandom_range(0, 2) != 0);
      ref_way   = 2'($urandom_range(0, 3));
      way_valid = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      #1 check((way_valid == 4'hF) ? "R3 random" : "R2 random",
               int'(victim_way), model_victim(way_valid));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule